// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block is the pin-facing I/O controller of a small microcontroller. It owns a 14-pin port that is accessed one bit at a time and thirteen 4-pin ports that are accessed a nibble at a time. Every pin has an output latch and an output-enable bit. The enable bits sit in control registers on a simple 4-bit register bus. A set of mode registers can take selected pins away from plain I/O and give them to interrupt, stop-cancel, event-counter and serial-port signals. The peripherals themselves live elsewhere; this block only presents their pin-side levels, with a two-flop synchronizer on every pin input.

Software writes nibble ports and control registers through `addr`/`wr_en`/`wr_data` and reads them back combinationally on `rd_data`. The bit port is driven by set and clear commands on `bit_op`/`bit_idx`, and any of its pins can be tested through `bit_level`. When `stop_mode` is asserted, every output buffer turns off at once, bus writes are ignored, and the block goes back to its reset state.

Register map (7-bit address): 0x004 serial pin select (bit0 clock pin, bit1 data-out pin); 0x005 serial enable (bit3); 0x024 interrupt pin select (bits 2:0); 0x025 misc pin select (bit0 event A, bit1 event B, bit2 stop-cancel, bit3 interrupt 0); 0x02C–0x02E bit-port enables; 0x030+k enables of nibble port k; 0x040+k data of nibble port k.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every `d_oe`/`r_oe` bit is 0, `d_out[11:0]` and all of `r_out` are 1, and every mode and enable register reads 0.
- R2: `bit_op`=01 sets and `bit_op`=10 clears the latch of bit-port pin `bit_idx` at the next edge, visible on `d_out`. Indices 12–15 change nothing, and codes 00/11 change nothing.
- R3: Bit-port pins 12 and 13 are input-only: their `d_oe` and `d_out` bits are always 0.
- R4: `bit_level` shows the level of `d_in[bit_idx]` two clock edges after it is applied, for indices 0–13. It is 0 for indices 14–15.
- R5: Register 0x02C+k (k=0..2) bit j enables the output of bit-port pin 4k+j and reads back as written.
- R6: Register 0x030+k (k=0..12) bit j enables nibble pin 4k+j unless a mode assigns that pin to a function, and reads back as written.
- R7: Writing 0x040+k loads the latch of nibble port k onto `r_out[4k+3:4k]` at the next edge. Reading 0x040+k returns the synchronized `r_in` nibble.
- R8: With bit2 of 0x025 set, `stopc_lvl` follows synchronized `d_in[12]`, and with bit3 set, `irq_lvl[0]` follows `d_in[13]`. Otherwise each is 1.
- R9: Bit i (i=0..2) of 0x024 routes nibble pin i to `irq_lvl[i+1]` and forces that pin's enable off. An unselected `irq_lvl` bit is 1.
- R10: Bits 0 and 1 of 0x025 route nibble pins 15 and 16 to `evt_lvl[0]` and `evt_lvl[1]` and force their enables off. Unselected, each is 0.
- R11: With 0x005 bit3 set, nibble pin 18 is the serial input (`ser_si`, enable off). With 0x004 bit0 also set, pin 17 drives `ser_sck_o`. With 0x004 bit1 also set, pin 19 drives `ser_so`. Both of those pins have their enable forced on. With bit3 clear, `ser_si` is 1.
- R12: While `stop_mode` is 1, all enables are 0 and bus writes are ignored. After it falls, all state is back at its reset values.
- R13: Writes to addresses outside the map change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_mode | input | 1 | Stop mode: outputs off, state held at reset |
| addr | input | 7 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Combinational read data |
| bit_op | input | 2 | Bit command: 01 set, 10 clear |
| bit_idx | input | 4 | Bit-port pin index |
| bit_level | output | 1 | Synchronized level of the indexed bit-port pin |
| d_in | input | 14 | Bit-port pin levels |
| d_out | output | 14 | Bit-port output values |
| d_oe | output | 14 | Bit-port output enables |
| r_in | input | 52 | Nibble-port pin levels |
| r_out | output | 52 | Nibble-port output values |
| r_oe | output | 52 | Nibble-port output enables |
| stopc_lvl | output | 1 | Stop-cancel pin level |
| irq_lvl | output | 4 | Interrupt pin levels 0–3 |
| evt_lvl | output | 2 | Event-counter pin levels |
| ser_sck_o | input | 1 | Serial clock from the serial engine |
| ser_so | input | 1 | Serial data out from the serial engine |
| ser_si | output | 1 | Serial data in to the serial engine |

## Verification
The bench builds the block with its default parameters: 13 nibble ports, a 14-pin bit port with 12 bidirectional pins, and a 7-bit address. With these values every one of the 128 addresses can be reached by random writes and reads, so the unmapped gaps between the register groups are exercised alongside the mapped ones. Every routed function pin, including the serial group on port 4, lies inside the modelled port range, so each mode selection can be seen at the pins.

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NIB = 13,
  parameter int DW  = 14,
  parameter int DIO = 12,
  parameter int AW  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_mode,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [3:0]      wr_data,
  output logic [3:0]      rd_data,
  input  logic [1:0]      bit_op,
  input  logic [3:0]      bit_idx,
  output logic            bit_level,
  input  logic [DW-1:0]   d_in,
  output logic [DW-1:0]   d_out,
  output logic [DW-1:0]   d_oe,
  input  logic [4*NIB-1:0] r_in,
  output logic [4*NIB-1:0] r_out,
  output logic [4*NIB-1:0] r_oe,
  output logic            stopc_lvl,
  output logic [3:0]      irq_lvl,
  output logic [1:0]      evt_lvl,
  input  logic            ser_sck_o,
  input  logic            ser_so,
  output logic            ser_si
);
  localparam int RW = 4*NIB;
  localparam int DREGS = DIO/4;
  localparam logic [AW-1:0] PMA_A  = AW'(7'h04);
  localparam logic [AW-1:0] SEN_A  = AW'(7'h05);
  localparam logic [AW-1:0] PMB_A  = AW'(7'h24);
  localparam logic [AW-1:0] PMC_A  = AW'(7'h25);
  localparam int DDCR_A = 'h2C;
  localparam int RDCR_A = 'h30;
  localparam int RDAT_A = 'h40;
  localparam int EVA_PIN = 15;
  localparam int EVB_PIN = 16;
  localparam int SCK_PIN = 17;
  localparam int SI_PIN  = 18;
  localparam int SO_PIN  = 19;

  logic [DIO-1:0] d_pdr, d_dcr;
  logic [RW-1:0]  r_pdr, r_dcr;
  logic [1:0]     pma;
  logic           sen;
  logic [2:0]     pmb;
  logic [3:0]     pmc;
  logic [DW-1:0]  d_s1, d_s2;
  logic [RW-1:0]  r_s1, r_s2;
  logic [RW-1:0]  in_mask, drv_mask, drv_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_pdr <= '1; d_dcr <= '0; r_pdr <= '1; r_dcr <= '0;
      pma <= '0; sen <= 1'b0; pmb <= '0; pmc <= '0;
      d_s1 <= '0; d_s2 <= '0; r_s1 <= '0; r_s2 <= '0;
    end else if (stop_mode) begin
      d_pdr <= '1; d_dcr <= '0; r_pdr <= '1; r_dcr <= '0;
      pma <= '0; sen <= 1'b0; pmb <= '0; pmc <= '0;
      d_s1 <= '0; d_s2 <= '0; r_s1 <= '0; r_s2 <= '0;
    end else begin
      d_s1 <= d_in; d_s2 <= d_s1;
      r_s1 <= r_in; r_s2 <= r_s1;
      if (int'(bit_idx) < DIO) begin
        if (bit_op == 2'b01) d_pdr[bit_idx] <= 1'b1;
        else if (bit_op == 2'b10) d_pdr[bit_idx] <= 1'b0;
      end
      if (wr_en) begin
        if (addr == PMA_A) pma <= wr_data[1:0];
        if (addr == SEN_A) sen <= wr_data[3];
        if (addr == PMB_A) pmb <= wr_data[2:0];
        if (addr == PMC_A) pmc <= wr_data;
        for (int k = 0; k < DREGS; k++)
          if (addr == AW'(DDCR_A + k)) d_dcr[4*k +: 4] <= wr_data;
        for (int k = 0; k < NIB; k++) begin
          if (addr == AW'(RDCR_A + k)) r_dcr[4*k +: 4] <= wr_data;
          if (addr == AW'(RDAT_A + k)) r_pdr[4*k +: 4] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == PMA_A) rd_data = {2'b00, pma};
    if (addr == SEN_A) rd_data = {sen, 3'b000};
    if (addr == PMB_A) rd_data = {1'b0, pmb};
    if (addr == PMC_A) rd_data = pmc;
    for (int k = 0; k < DREGS; k++)
      if (addr == AW'(DDCR_A + k)) rd_data = d_dcr[4*k +: 4];
    for (int k = 0; k < NIB; k++) begin
      if (addr == AW'(RDCR_A + k)) rd_data = r_dcr[4*k +: 4];
      if (addr == AW'(RDAT_A + k)) rd_data = r_s2[4*k +: 4];
    end
  end

  always_comb begin
    in_mask = '0;
    in_mask[2:0] = pmb;
    in_mask[EVA_PIN] = pmc[0];
    in_mask[EVB_PIN] = pmc[1];
    in_mask[SI_PIN] = sen;
    drv_mask = '0;
    drv_mask[SCK_PIN] = sen & pma[0];
    drv_mask[SO_PIN]  = sen & pma[1];
    drv_val = '0;
    drv_val[SCK_PIN] = ser_sck_o;
    drv_val[SO_PIN]  = ser_so;
  end

  assign bit_level = (int'(bit_idx) < DW) ? d_s2[bit_idx] : 1'b0;
  assign d_out = {{(DW-DIO){1'b0}}, d_pdr};
  assign d_oe  = {{(DW-DIO){1'b0}}, d_dcr & {DIO{~stop_mode}}};
  assign r_out = (r_pdr & ~drv_mask) | (drv_val & drv_mask);
  assign r_oe  = ((r_dcr & ~in_mask) | drv_mask) & {RW{~stop_mode}};

  assign stopc_lvl  = pmc[2] ? d_s2[DIO]   : 1'b1;
  assign irq_lvl[0] = pmc[3] ? d_s2[DIO+1] : 1'b1;
  assign irq_lvl[1] = pmb[0] ? r_s2[0] : 1'b1;
  assign irq_lvl[2] = pmb[1] ? r_s2[1] : 1'b1;
  assign irq_lvl[3] = pmb[2] ? r_s2[2] : 1'b1;
  assign evt_lvl[0] = pmc[0] & r_s2[EVA_PIN];
  assign evt_lvl[1] = pmc[1] & r_s2[EVB_PIN];
  assign ser_si     = sen ? r_s2[SI_PIN] : 1'b1;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NIB = 13,
  parameter int DW  = 14,
  parameter int DIO = 12,
  parameter int AW  = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stop_mode,
  input logic [AW-1:0]   addr,
  input logic            wr_en,
  input logic [3:0]      wr_data,
  input logic [1:0]      bit_op,
  input logic [3:0]      bit_idx,
  input logic [DW-1:0]   d_out,
  input logic [DW-1:0]   d_oe,
  input logic [4*NIB-1:0] r_out,
  input logic [4*NIB-1:0] r_oe
);
  assert_stop_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> (d_oe == '0 && r_oe == '0));

  assert_stop_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> (d_out[DIO-1:0] == '1 && r_oe == '0 && d_oe == '0));

  assert_bit_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && bit_op == 2'b01 && int'(bit_idx) < DIO) |=> d_out[$past(bit_idx)]);

  assert_bit_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && bit_op == 2'b10 && int'(bit_idx) < DIO) |=> !d_out[$past(bit_idx)]);

  for (genvar k = 0; k < NIB; k++) begin : g_nib
    if (k != 4) begin : g_chk
      assert_nib_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stop_mode && addr == AW'('h40 + k)) |=> (r_out[4*k +: 4] == $past(wr_data)));
    end
  end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NIB(NIB), .DW(DW), .DIO(DIO), .AW(AW)) u_chk (.*);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int NIB = 13, DW = 14, DIO = 12, AW = 7, RW = 4*NIB;

  logic clk = 0, rst_n = 0, stop_mode = 0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 0;
  logic [3:0] wr_data = '0, rd_data;
  logic [1:0] bit_op = '0;
  logic [3:0] bit_idx = '0;
  logic bit_level;
  logic [DW-1:0] d_in = '0, d_out, d_oe;
  logic [RW-1:0] r_in = '0, r_out, r_oe;
  logic stopc_lvl, ser_si, ser_sck_o = 0, ser_so = 0;
  logic [3:0] irq_lvl;
  logic [1:0] evt_lvl;

  int checks = 0, failures = 0;

  logic [DIO-1:0] m_dpdr, m_ddcr;
  logic [RW-1:0]  m_rpdr, m_rdcr;
  logic [1:0] m_pma; logic m_sen; logic [2:0] m_pmb; logic [3:0] m_pmc;

  gpio_port_ctrl #(.NIB(NIB), .DW(DW), .DIO(DIO), .AW(AW)) dut (.*);

  always #2.5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dpdr = '1; m_ddcr = '0; m_rpdr = '1; m_rdcr = '0;
    m_pma = '0; m_sen = 0; m_pmb = '0; m_pmc = '0;
  endtask

  function automatic logic [RW-1:0] inmask();
    logic [RW-1:0] m = '0;
    m[2:0] = m_pmb; m[15] = m_pmc[0]; m[16] = m_pmc[1]; m[18] = m_sen;
    return m;
  endfunction

  function automatic logic [RW-1:0] exp_roe();
    logic [RW-1:0] o = m_rdcr & ~inmask();
    if (m_sen && m_pma[0]) o[17] = 1'b1;
    if (m_sen && m_pma[1]) o[19] = 1'b1;
    return o;
  endfunction

  function automatic logic [RW-1:0] exp_rout();
    logic [RW-1:0] o = m_rpdr;
    if (m_sen && m_pma[0]) o[17] = ser_sck_o;
    if (m_sen && m_pma[1]) o[19] = ser_so;
    return o;
  endfunction

  function automatic logic [3:0] exp_rd(logic [AW-1:0] a);
    int ai = int'(a);
    if (ai == 'h04) return {2'b00, m_pma};
    if (ai == 'h05) return {m_sen, 3'b000};
    if (ai == 'h24) return {1'b0, m_pmb};
    if (ai == 'h25) return m_pmc;
    if (ai >= 'h2C && ai <= 'h2E) return m_ddcr[4*(ai-'h2C) +: 4];
    if (ai >= 'h30 && ai < 'h30 + NIB) return m_rdcr[4*(ai-'h30) +: 4];
    if (ai >= 'h40 && ai < 'h40 + NIB) return r_in[4*(ai-'h40) +: 4];
    return 4'h0;
  endfunction

  task automatic bus_wr(logic [AW-1:0] a, logic [3:0] d);
    int ai = int'(a);
    @(negedge clk); addr = a; wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (ai == 'h04) m_pma = d[1:0];
    if (ai == 'h05) m_sen = d[3];
    if (ai == 'h24) m_pmb = d[2:0];
    if (ai == 'h25) m_pmc = d;
    if (ai >= 'h2C && ai <= 'h2E) m_ddcr[4*(ai-'h2C) +: 4] = d;
    if (ai >= 'h30 && ai < 'h30 + NIB) m_rdcr[4*(ai-'h30) +: 4] = d;
    if (ai >= 'h40 && ai < 'h40 + NIB) m_rpdr[4*(ai-'h40) +: 4] = d;
  endtask

  task automatic bit_cmd(logic [1:0] op, logic [3:0] i);
    @(negedge clk); bit_op = op; bit_idx = i;
    @(negedge clk); bit_op = 2'b00;
    if (int'(i) < DIO && op == 2'b01) m_dpdr[i] = 1'b1;
    if (int'(i) < DIO && op == 2'b10) m_dpdr[i] = 1'b0;
  endtask

  task automatic settle_and_check(logic [AW-1:0] ra, logic [3:0] ti);
    repeat (2) @(negedge clk);
    chk("R2/R3 d_out", 64'(d_out), 64'({2'b00, m_dpdr}));
    chk("R5/R3 d_oe", 64'(d_oe), 64'({2'b00, m_ddcr}));
    chk("R7/R11 r_out", 64'(r_out), 64'(exp_rout()));
    chk("R6/R9/R10/R11 r_oe", 64'(r_oe), 64'(exp_roe()));
    chk("R8 stopc_lvl", 64'(stopc_lvl), 64'(m_pmc[2] ? d_in[12] : 1'b1));
    chk("R8/R9 irq_lvl", 64'(irq_lvl), 64'({m_pmb[2] ? r_in[2] : 1'b1, m_pmb[1] ? r_in[1] : 1'b1,
                                          m_pmb[0] ? r_in[0] : 1'b1, m_pmc[3] ? d_in[13] : 1'b1}));
    chk("R10 evt_lvl", 64'(evt_lvl), 64'({m_pmc[1] & r_in[16], m_pmc[0] & r_in[15]}));
    chk("R11 ser_si", 64'(ser_si), 64'(m_sen ? r_in[18] : 1'b1));
    addr = ra; bit_idx = ti; #1;
    chk("R13/R5/R6/R7 rd_data", 64'(rd_data), 64'(exp_rd(ra)));
    chk("R4 bit_level", 64'(bit_level), 64'(int'(ti) < DW ? d_in[ti] : 1'b0));
  endtask

  initial begin
    logic [AW-1:0] maps [0:5];
    void'($urandom(32'd20240611));
    model_reset();
    maps[0] = 7'h04; maps[1] = 7'h05; maps[2] = 7'h24;
    maps[3] = 7'h25; maps[4] = 7'h2C; maps[5] = 7'h30;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    settle_and_check(7'h25, 4'd0);
    settle_and_check(7'h04, 4'd13);
    settle_and_check(7'h2E, 4'd15);

    // R2 boundary: indices 11..15 and no-op codes
    bit_cmd(2'b10, 4'd11); settle_and_check(7'h7F, 4'd11);
    bit_cmd(2'b10, 4'd12); bit_cmd(2'b10, 4'd15); bit_cmd(2'b11, 4'd0); bit_cmd(2'b00, 4'd1);
    settle_and_check(7'h00, 4'd14);

    // R8/R9/R10/R11 directed selections
    d_in = 14'h1000; r_in = '0; r_in[18] = 1; r_in[15] = 1; r_in[1] = 1;
    bus_wr(7'h30, 4'hF); bus_wr(7'h33, 4'hF); bus_wr(7'h34, 4'hF);
    bus_wr(7'h24, 4'h7); bus_wr(7'h25, 4'hF);
    bus_wr(7'h05, 4'h8); bus_wr(7'h04, 4'h3);
    ser_sck_o = 1; ser_so = 0;
    settle_and_check(7'h40, 4'd12);
    settle_and_check(7'h44, 4'd13);

    // R13 unmapped writes
    bus_wr(7'h26, 4'hF); bus_wr(7'h2F, 4'hF); bus_wr(7'h4D, 4'h0); bus_wr(7'h7F, 4'h5);
    settle_and_check(7'h2F, 4'd3);

    // R12 stop mode
    bus_wr(7'h2C, 4'hF); bit_cmd(2'b10, 4'd2);
    @(negedge clk); stop_mode = 1; addr = 7'h2D; wr_en = 1; wr_data = 4'hF; #1;
    chk("R12 d_oe in stop", 64'(d_oe), 64'h0);
    chk("R12 r_oe in stop", 64'(r_oe), 64'h0);
    @(negedge clk); wr_en = 0;
    @(negedge clk); stop_mode = 0;
    model_reset();
    settle_and_check(7'h2D, 4'd2);
    settle_and_check(7'h05, 4'd12);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int act = $urandom % 4;
      logic [63:0] rv;
      if (act == 0) bus_wr(maps[$urandom % 6] + AW'($urandom % 3), 4'($urandom));
      else if (act == 1) bus_wr(AW'($urandom), 4'($urandom));
      else if (act == 2) bit_cmd(2'($urandom), 4'($urandom));
      else begin
        rv = {$urandom, $urandom};
        @(negedge clk);
        d_in = DW'($urandom); r_in = rv[RW-1:0];
        ser_sck_o = 1'($urandom); ser_so = 1'($urandom);
      end
      settle_and_check(($urandom % 2) ? AW'($urandom) : maps[$urandom % 6] + AW'($urandom % 3),
                       4'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule